// File: doc/BRIEF.md
# Paged Address Translator with Byte-Lane Swap

This block sits between a network controller that issues 24-bit addresses and a local RAM. It discards the four most significant address bits and splits the remaining 20 bits into a 10-bit slot index and a 10-bit offset within a 1024-byte page. The slot index selects one of 1024 sixteen-bit page entries. Each entry supplies three things: a 12-bit frame number, a flag that sends the access to the auxiliary backplane instead of on-board memory, and a flag that exchanges the two bytes of every data word. The physical address is the frame number placed above the offset.

A host writes and reads the page map through a small indexed port. Because the top nibble is dropped, an address such as 0xFFFFF4 falls in slot 1023. That slot can be pointed at any frame, including frame 0, so a fixed high pointer can alias low RAM. On-board memory holds 256 pages. An on-board access to a higher frame is refused and reported instead of being issued.

A three-state controller manages each controller access. In `ST_IDLE` it accepts a request (`req_valid` with `req_ready`) and captures the looked-up entry. It then moves to `ST_ISSUE` if the frame is legal, or to `ST_FAULT` if it is not. `ST_ISSUE` presents the RAM access and holds it until `mem_ready`, then returns to `ST_IDLE`. `ST_FAULT` lasts one cycle and returns to `ST_IDLE`.

Top module: `pxl_top`

## Requirements
- R1: After reset, every page entry reads 0x0000, `req_ready` is 1 and `mem_valid` is 0. A request to a slot that has not been written maps to frame 0 with no swap and on-board memory.
- R2: Controller address bits 23:20 are ignored, bits 19:10 select the slot, and `mem_addr` equals {entry bits 11:0, address bits 9:0}. It appears the cycle after acceptance.
- R3: A host read with `hst_rd_en` returns the entry at `hst_idx` on `hst_rdata` one clock later.
- R4: A host write with `hst_wr_en` is used by lookups from the next clock on. A request accepted in the same cycle as the write sees the old entry.
- R5: `mem_aux` equals bit 13 of the entry used: 1 for backplane memory, 0 for on-board memory.
- R6: When entry bit 15 is 1, `mem_wdata` is `req_wdata` with bits 15:8 and 7:0 exchanged, and `ctl_rdata` is `mem_rdata` exchanged the same way. When bit 15 is 0, both pass through unchanged.
- R7: A word access drives `mem_be` = 2'b11. A byte access (`req_byte`=1) drives 2'b10 when (address bit 0 XOR entry bit 15) is 1, and 2'b01 otherwise.
- R8: An on-board access (bit 13 = 0) whose frame is 256 or higher never raises `mem_valid`. Instead, `range_err` is high for exactly the cycle after acceptance.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` stays 1, the access fields stay stable and `req_ready` stays 0.
- R10: Address 0xFFFFF4, and any address with a different top nibble, translates through slot 1023 at offset 0x3F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host page-entry write strobe |
| hst_rd_en | input | 1 | Host page-entry read strobe |
| hst_idx | input | 10 | Host slot index |
| hst_wdata | input | 16 | Host entry write value |
| hst_rdata | output | 16 | Host entry read value, one clock after the strobe |
| req_valid | input | 1 | Controller request valid |
| req_ready | output | 1 | Block can accept a request (state `ST_IDLE`) |
| req_addr | input | 24 | Controller byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_wdata | input | 16 | Controller write data |
| ctl_rdata | output | 16 | Read data returned to the controller, lane-corrected |
| mem_valid | output | 1 | RAM access presented (state `ST_ISSUE`) |
| mem_ready | input | 1 | RAM takes the access |
| mem_addr | output | 22 | Physical byte address {frame, offset} |
| mem_aux | output | 1 | 1 = auxiliary backplane memory, 0 = on-board memory |
| mem_we | output | 1 | RAM write enable |
| mem_be | output | 2 | RAM byte enables (bit 1 = bits 15:8) |
| mem_wdata | output | 16 | Lane-corrected RAM write data |
| mem_rdata | input | 16 | RAM read data |
| range_err | output | 1 | Refused on-board access (state `ST_FAULT`) |

## Verification
An accepted request produces its RAM access or its `range_err` pulse in the cycle right after the accepting edge. A host read returns data one edge after the strobe. `ctl_rdata` follows `mem_rdata` in the same cycle as the access. The driver pushes each expected access into a queue before the accepting edge. The monitor samples on the falling edge and pops one item whenever `mem_valid` and `mem_ready` are both high, or `range_err` is high, so every comparison lands on the cycle where the result is due. Stalls, and a host write made in the same cycle as a request, are checked on the falling edges around the event.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    // Page entry layout: swap flag at 15, memory select at 13, frame at 11:0.
    typedef struct packed {
        logic        swap;
        logic        rsv14;
        logic        aux;
        logic        rsv12;
        logic [11:0] frame;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } xl_state_e;
endpackage

// File: rtl/pxl_pagemap.sv
module pxl_pagemap
    import pxl_pkg::*;
#(
    parameter int SLOTS = 1024,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pte_t             wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output pte_t             rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output pte_t             lk_entry
);
    pte_t map_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) map_q[i] <= '0;
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= map_q[rd_idx];
    end

    // Lookup sees the stored entry; a write in the same cycle lands at the edge.
    assign lk_entry = map_q[lk_idx];

    // A read issued the cycle after a write to the same slot returns the new value.
    assert_wr_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && $past(wr_en) && rd_idx == $past(wr_idx))
        |=> rd_data == $past(wr_data, 2));
endmodule

// File: rtl/pxl_lane.sv
module pxl_lane #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              swap,
    input  logic              byte_acc,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ctl_rdata
);
    logic [DATA_W-1:0] w_swapped;
    logic [DATA_W-1:0] r_swapped;

    // Reverse byte order across the word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign w_swapped[g*8 +: 8] = ctl_wdata[(LANES-1-g)*8 +: 8];
        assign r_swapped[g*8 +: 8] = mem_rdata[(LANES-1-g)*8 +: 8];
    end

    assign mem_wdata = swap ? w_swapped : ctl_wdata;
    assign ctl_rdata = swap ? r_swapped : mem_rdata;

    always_comb begin
        if (!byte_acc)              mem_be = '1;
        else if (lane_hi ^ swap)    mem_be = LANES'(2'b10);
        else                        mem_be = LANES'(2'b01);
    end
endmodule

// File: rtl/pxl_ctrl.sv
module pxl_ctrl
    import pxl_pkg::*;
#(
    parameter int SIG_W         = 20,
    parameter int OFS_W         = 10,
    parameter int FRAME_W       = 12,
    parameter int ONBOARD_PAGES = 256,
    parameter int DATA_W        = 16,
    localparam int IDX_W        = SIG_W - OFS_W,
    localparam int PA_W         = FRAME_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SIG_W-1:0]  req_addr,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [IDX_W-1:0]  lk_idx,
    input  pte_t              lk_entry,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_aux,
    output logic              mem_we,
    output logic              swap_q,
    output logic              byte_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              range_err
);
    xl_state_e state_q, state_d;
    pte_t              entry_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              write_q;
    logic              accept;
    logic              bad_frame;
    logic              unused_rsv;

    assign lk_idx    = req_addr[SIG_W-1:OFS_W];
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign bad_frame = !lk_entry.aux && (lk_entry.frame >= FRAME_W'(ONBOARD_PAGES));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = bad_frame ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: if (mem_ready) state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= '0;
            ofs_q   <= '0;
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            entry_q <= lk_entry;
            ofs_q   <= req_addr[OFS_W-1:0];
            write_q <= req_write;
            byte_q  <= req_byte;
            wdata_q <= req_wdata;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        range_err = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: mem_valid = 1'b1;
            ST_FAULT: range_err = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign mem_addr   = {entry_q.frame, ofs_q};
    assign mem_aux    = entry_q.aux;
    assign mem_we     = write_q;
    assign swap_q     = entry_q.swap;
    assign unused_rsv = entry_q.rsv14 ^ entry_q.rsv12;

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && !req_ready && $stable(mem_addr)
                                      && $stable(mem_we) && $stable(mem_aux)));

    assert_fault_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> ($past(req_valid) && $past(req_ready)));

    assert_fault_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> !mem_valid);
endmodule

// File: rtl/pxl_top.sv
module pxl_top
    import pxl_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int SIG_W         = 20,
    parameter int OFS_W         = 10,
    parameter int FRAME_W       = 12,
    parameter int ONBOARD_PAGES = 256,
    parameter int DATA_W        = 16,
    localparam int IDX_W        = SIG_W - OFS_W,
    localparam int SLOTS        = 1 << IDX_W,
    localparam int PA_W         = FRAME_W + OFS_W,
    localparam int LANES        = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr_en,
    input  logic              hst_rd_en,
    input  logic [IDX_W-1:0]  hst_idx,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_aux,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              range_err
);
    logic [IDX_W-1:0]  lk_idx;
    pte_t              lk_entry;
    pte_t              rd_entry;
    logic              swap_q;
    logic              byte_q;
    logic [DATA_W-1:0] wdata_q;
    logic              unused_hi;

    // Top nibble of the controller address is not decoded.
    assign unused_hi = ^req_addr[ADDR_W-1:SIG_W];
    assign hst_rdata = rd_entry;

    pxl_pagemap #(.SLOTS(SLOTS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hst_wr_en),
        .wr_idx  (hst_idx),
        .wr_data (pte_t'(hst_wdata)),
        .rd_en   (hst_rd_en),
        .rd_idx  (hst_idx),
        .rd_data (rd_entry),
        .lk_idx  (lk_idx),
        .lk_entry(lk_entry)
    );

    pxl_ctrl #(
        .SIG_W(SIG_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W),
        .ONBOARD_PAGES(ONBOARD_PAGES), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr[SIG_W-1:0]),
        .req_write(req_write),
        .req_byte (req_byte),
        .req_wdata(req_wdata),
        .lk_idx   (lk_idx),
        .lk_entry (lk_entry),
        .mem_valid(mem_valid),
        .mem_ready(mem_ready),
        .mem_addr (mem_addr),
        .mem_aux  (mem_aux),
        .mem_we   (mem_we),
        .swap_q   (swap_q),
        .byte_q   (byte_q),
        .wdata_q  (wdata_q),
        .range_err(range_err)
    );

    pxl_lane #(.DATA_W(DATA_W)) u_lane (
        .swap     (swap_q),
        .byte_acc (byte_q),
        .lane_hi  (mem_addr[0]),
        .ctl_wdata(wdata_q),
        .mem_rdata(mem_rdata),
        .mem_be   (mem_be),
        .mem_wdata(mem_wdata),
        .ctl_rdata(ctl_rdata)
    );

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_valid
                                     || mem_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));

    assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && byte_q) |-> $countones(mem_be) == 1);
endmodule

// File: tb/pxl_top_tb.sv
module pxl_top_tb;
    typedef struct packed {
        logic        err;
        logic [21:0] addr;
        logic        aux;
        logic        we;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en = 1'b0, hst_rd_en = 1'b0;
    logic [9:0]  hst_idx = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0, req_byte = 1'b0;
    logic [15:0] req_wdata = '0, ctl_rdata;
    logic        mem_valid, mem_ready = 1'b1;
    logic [21:0] mem_addr;
    logic        mem_aux, mem_we, range_err;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'hA55C;

    int nvec = 0, nbad = 0;
    logic [15:0] model [1024];
    exp_t sb [$];

    always #10 clk = ~clk;

    pxl_top u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [23:0] a, input logic w, input logic b,
                                     input logic [15:0] d, input logic [15:0] e);
        exp_t x;
        logic sw;
        sw     = e[15];
        x.err  = !e[13] && (e[11:0] >= 12'd256);
        x.addr = {e[11:0], a[9:0]};
        x.aux  = e[13];
        x.we   = w;
        x.be   = !b ? 2'b11 : ((a[0] ^ sw) ? 2'b10 : 2'b01);
        x.wd   = sw ? {d[7:0], d[15:8]} : d;
        x.rd   = sw ? {mem_rdata[7:0], mem_rdata[15:8]} : mem_rdata;
        return x;
    endfunction

    task automatic host_wr(input logic [9:0] i, input logic [15:0] v);
        @(negedge clk);
        hst_wr_en = 1'b1; hst_idx = i; hst_wdata = v;
        @(negedge clk);
        hst_wr_en = 1'b0;
        model[i] = v;
    endtask

    task automatic host_rd(input logic [9:0] i, input logic [15:0] e, input string req);
        @(negedge clk);
        hst_rd_en = 1'b1; hst_idx = i;
        @(negedge clk);
        hst_rd_en = 1'b0;
        chk(req, 32'(hst_rdata), 32'(e));
    endtask

    // Driver: push the expected access, then present the request.
    task automatic issue(input logic [23:0] a, input logic w, input logic b, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sb.push_back(predict(a, w, b, d, model[a[19:10]]));
        req_valid = 1'b1; req_addr = a; req_write = w; req_byte = b; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare on the cycle after acceptance (or after the stall ends).
    always @(negedge clk) begin
        if (rst_n && ((mem_valid && mem_ready) || range_err)) begin
            if (sb.size() == 0) begin
                nvec++; nbad++;
                $display("FAIL R2 actual=unexpected access expected=none");
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk("R8 err", 32'(range_err), 32'(x.err));
                if (!x.err) begin
                    chk("R2 addr", 32'(mem_addr), 32'(x.addr));
                    chk("R5 aux", 32'(mem_aux), 32'(x.aux));
                    chk("R7 be", 32'(mem_be), 32'(x.be));
                    if (x.we) chk("R6 wdata", 32'(mem_wdata), 32'(x.wd));
                    else      chk("R6 rdata", 32'(ctl_rdata), 32'(x.rd));
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 valid", 32'(mem_valid), 32'd0);
        host_rd(10'd0, 16'h0000, "R1 slot0");
        host_rd(10'd1023, 16'h0000, "R1 slot1023");
        issue(24'h000123, 1'b0, 1'b0, 16'h0);           // R1 unwritten slot
        // R3 host write/read, R2 translation with top nibble ignored
        host_wr(10'd5, 16'h002A);
        host_rd(10'd5, 16'h002A, "R3 readback");
        issue(24'hA0143C, 1'b0, 1'b0, 16'h0);           // R2
        issue(24'h001401, 1'b1, 1'b1, 16'h7700);        // R7 odd byte, no swap -> 10
        issue(24'h001400, 1'b1, 1'b1, 16'h0077);        // R7 even byte, no swap -> 01
        // R6 swap
        host_wr(10'd6, 16'h8010);
        issue(24'h001802, 1'b1, 1'b0, 16'h1234);        // R6 write swap
        issue(24'h001804, 1'b0, 1'b0, 16'h0);           // R6 read swap
        issue(24'h001805, 1'b1, 1'b1, 16'hAB00);        // R7 odd byte, swap -> 01
        issue(24'h001806, 1'b1, 1'b1, 16'h00CD);        // R7 even byte, swap -> 10
        // R5 aux memory with a high frame, R8 range check
        host_wr(10'd7, 16'h2300);
        issue(24'h001C10, 1'b0, 1'b0, 16'h0);           // R5
        host_wr(10'd8, 16'h0100);
        issue(24'h002000, 1'b1, 1'b0, 16'h5555);        // R8 frame 256 refused
        host_wr(10'd8, 16'h00FF);
        issue(24'h002000, 1'b0, 1'b0, 16'h0);           // R8 frame 255 allowed
        // R10 slot 1023 aliases the top of the space
        host_wr(10'd1023, 16'h0003);
        issue(24'hFFFFF4, 1'b0, 1'b0, 16'h0);           // R10
        issue(24'h0FFFF4, 1'b0, 1'b0, 16'h0);           // R10
        // R4 same-cycle write sees the old entry
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sb.push_back(predict(24'h002404, 1'b0, 1'b0, 16'h0, model[9]));
        req_valid = 1'b1; req_addr = 24'h002404; req_write = 1'b0; req_byte = 1'b0;
        hst_wr_en = 1'b1; hst_idx = 10'd9; hst_wdata = 16'h0044;
        @(negedge clk);
        req_valid = 1'b0; hst_wr_en = 1'b0;
        model[9] = 16'h0044;
        issue(24'h002404, 1'b0, 1'b0, 16'h0);           // R4 new entry used
        // R9 stall
        @(negedge clk);
        mem_ready = 1'b0;
        issue(24'h001408, 1'b1, 1'b0, 16'hBEEF);
        repeat (2) begin
            chk("R9 valid held", 32'(mem_valid), 32'd1);
            chk("R9 not ready", 32'(req_ready), 32'd0);
            chk("R9 addr held", 32'(mem_addr), 32'({12'h02A, 10'h008}));
            @(negedge clk);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 released", 32'(req_ready), 32'd1);
        repeat (3) @(negedge clk);
        chk("R2 queue drained", 32'(sb.size()), 32'd0);
        finish_run();
    end
endmodule